// File: doc/BRIEF.md
# Pad attribute register file

This block holds one attribute word for every pad of a chip. There are two groups of pads: multiplexed pads and dedicated pads. Each group has its own count and its own packed output array. Software reaches the words through a plain register port with address, write enable, write data and read data. Each stored word goes straight from its register to the pad wrappers, where its fields set inversion, open-drain behaviour, pulls, keeper, Schmitt trigger, slew rate and drive strength.

Each pad group has a parameter mask of the attribute bits that the pad technology supports. A write stores the written data ANDed with that mask. Software can therefore find out which features exist by writing all ones and reading the word back. A global enable register guards every attribute write. Clearing it closes the register file for good. Only a reset opens it again.

The attribute word is 13 bits wide:

| Bits | Field |
|------|-------|
| 0 | inversion |
| 1 | virtual open-drain |
| 2 | pull enable |
| 3 | pull direction (1 = up) |
| 4 | keeper |
| 5 | Schmitt trigger |
| 6 | true open-drain |
| 8:7 | slew rate (3 = fastest) |
| 12:9 | drive strength (15 = strongest) |

Top module: `padattr_regfile`

## Requirements
- R1: After a synchronous reset, every attribute word is zero, read data is zero, and the enable register reads back 1 in bit 0.
- R2: The address map is byte addressed and word aligned. Offset 0x00 is the enable register. Multiplexed pad i is at 0x04+4*i. Dedicated pad j is at 0x04+4*(NUM_MUX+j). A write changes only the addressed pad's output word, and the change shows one clock after the write.
- R3: Read data is registered. The value returned one clock after an address is presented is the word as it stood before any write made in that same cycle.
- R4: An address with nonzero low two bits, or one beyond the last pad, reads as zero. A write to such an address changes nothing.
- R5: Bit 0 (inversion) and bit 1 (virtual open-drain) are always stored as written, whatever the masks say.
- R6: All other fields are write-any-read-legal: the stored word is the write data ANDed with the group mask. By default the multiplexed mask allows all 13 bits. The dedicated mask lacks drive-strength bits 12:11, so a write of 0x1FFF to a dedicated pad reads back 0x07FF.
- R7: Writing the enable register with bit 0 clear locks the file. Later attribute writes are accepted without error but have no effect, and reads still return the stored words.
- R8: Once the file is locked, writing 1 to the enable register does not unlock it, and the enable register reads 0.
- R9: Only a reset clears the lock. After a reset, attribute writes take effect again.
- R10: Write data bits at and above bit 13 are discarded, and read data bits 31:13 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_addr_i | input | ADDR_W | Byte address of the register |
| cfg_we_i | input | 1 | Write strobe for this cycle |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_rdata_o | output | DATA_W | Registered read data for the previous cycle's address |
| mux_attr_o | output | NUM_MUX*ATTR_W | Attribute words of the multiplexed pads |
| ded_attr_o | output | NUM_DED*ATTR_W | Attribute words of the dedicated pads |

## Verification
Every cycle both reads the presented address and may write it. A read and a write of the same word can therefore meet in one clock. The bench provokes this by writing a pad while its address is on the port. It expects the returned word to be the value from before the write, and it expects the pad output to carry the new value one clock later. The bench also places a lock write directly before an attribute write. In that case the attribute write must leave both the readback and the pad outputs unchanged.

// File: rtl/padattr_pkg.sv
package padattr_pkg;
  // Attribute word field positions
  localparam int ATTR_BITS   = 13;
  localparam int F_INVERT    = 0;
  localparam int F_VIRT_OD   = 1;
  localparam int F_PULL_EN   = 2;
  localparam int F_PULL_UP   = 3;
  localparam int F_KEEPER    = 4;
  localparam int F_SCHMITT   = 5;
  localparam int F_OPEN_DRN  = 6;
  localparam int F_SLEW_LSB  = 7;
  localparam int F_DRIVE_LSB = 9;

  // Bits that stay writable regardless of technology masks
  localparam logic [ATTR_BITS-1:0] ALWAYS_RW =
    ATTR_BITS'((1 << F_INVERT) | (1 << F_VIRT_OD));
endpackage

// File: rtl/padattr_decode.sv
module padattr_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_PADS = 20
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_lock_o,
  output logic [NUM_PADS-1:0] sel_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign word       = addr_i[ADDR_W-1:2];
  assign hit_lock_o = aligned && (word == '0);

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_sel
    assign sel_o[i] = aligned && (word == WORD_W'(i + 1));
  end
endmodule

// File: rtl/padattr_lock.sv
module padattr_lock (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic locked_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)                 locked_o <= 1'b0;
    else if (wr_i && !wbit_i)  locked_o <= 1'b1;
  end

  // one-way: nothing but reset clears it
  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_o |=> locked_o);
endmodule

// File: rtl/padattr_slot.sv
module padattr_slot #(
  parameter int                ATTR_W = 13,
  parameter logic [ATTR_W-1:0] LEGAL  = '1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              locked_i,
  input  logic [ATTR_W-1:0] wdata_i,
  output logic [ATTR_W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)        q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i & LEGAL;
  end

  assert_legal_bits_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_o & ~LEGAL) == '0);

  assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_i |=> $stable(q_o));
endmodule

// File: rtl/padattr_rdmux.sv
module padattr_rdmux #(
  parameter int ATTR_W   = 13,
  parameter int DATA_W   = 32,
  parameter int NUM_PADS = 20
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic                             hit_lock_i,
  input  logic                             locked_i,
  input  logic [NUM_PADS-1:0]              sel_i,
  input  logic [NUM_PADS-1:0][ATTR_W-1:0]  attr_i,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [DATA_W-1:0] rd_next;
  logic              any_hit;

  assign any_hit = hit_lock_i || (|sel_i);

  always_comb begin
    rd_next = '0;
    if (hit_lock_i) rd_next[0] = ~locked_i;
    for (int i = 0; i < NUM_PADS; i++) begin
      if (sel_i[i]) rd_next = rd_next | DATA_W'(attr_i[i]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_next;
  end

  assert_unmapped_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !any_hit |=> (rdata_o == '0));

  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    rdata_o[DATA_W-1:ATTR_W] == '0);
endmodule

// File: rtl/padattr_regfile.sv
module padattr_regfile #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ATTR_W  = padattr_pkg::ATTR_BITS,
  parameter int NUM_MUX = 4,
  parameter int NUM_DED = 16,
  parameter logic [ATTR_W-1:0] MUX_LEGAL = 13'h1FFF,
  parameter logic [ATTR_W-1:0] DED_LEGAL = 13'h07FC
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic [ADDR_W-1:0]                cfg_addr_i,
  input  logic                             cfg_we_i,
  input  logic [DATA_W-1:0]                cfg_wdata_i,
  output logic [DATA_W-1:0]                cfg_rdata_o,
  output logic [NUM_MUX-1:0][ATTR_W-1:0]   mux_attr_o,
  output logic [NUM_DED-1:0][ATTR_W-1:0]   ded_attr_o
);
  localparam int NUM_PADS = NUM_MUX + NUM_DED;
  localparam logic [ATTR_W-1:0] FIXED_RW = padattr_pkg::ALWAYS_RW;

  logic                            hit_lock;
  logic [NUM_PADS-1:0]             sel;
  logic                            locked;
  logic [NUM_PADS-1:0][ATTR_W-1:0] slot_q;
  logic                            unused_wdata_hi;

  assign unused_wdata_hi = ^cfg_wdata_i[DATA_W-1:ATTR_W];

  padattr_decode #(.ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS)) u_decode (
    .addr_i     (cfg_addr_i),
    .hit_lock_o (hit_lock),
    .sel_o      (sel)
  );

  padattr_lock u_lock (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_i     (cfg_we_i && hit_lock),
    .wbit_i   (cfg_wdata_i[0]),
    .locked_o (locked)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_slot
    localparam logic [ATTR_W-1:0] SLOT_MASK =
      ((i < NUM_MUX) ? MUX_LEGAL : DED_LEGAL) | FIXED_RW;
    padattr_slot #(.ATTR_W(ATTR_W), .LEGAL(SLOT_MASK)) u_slot (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_en_i  (cfg_we_i && sel[i] && !locked),
      .locked_i (locked),
      .wdata_i  (cfg_wdata_i[ATTR_W-1:0]),
      .q_o      (slot_q[i])
    );
  end

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux_out
    assign mux_attr_o[m] = slot_q[m];
  end
  for (genvar d = 0; d < NUM_DED; d++) begin : g_ded_out
    assign ded_attr_o[d] = slot_q[NUM_MUX + d];
  end

  padattr_rdmux #(.ATTR_W(ATTR_W), .DATA_W(DATA_W), .NUM_PADS(NUM_PADS)) u_rdmux (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hit_lock_i (hit_lock),
    .locked_i   (locked),
    .sel_i      (sel),
    .attr_i     (slot_q),
    .rdata_o    (cfg_rdata_o)
  );

  assert_decode_onehot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({sel, hit_lock}));

  assert_fixed_bits_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_we_i && sel[0] && !locked) |=> (mux_attr_o[0][1:0] == $past(cfg_wdata_i[1:0])));
endmodule

// File: tb/padattr_regfile_bench.sv
module padattr_regfile_bench;
  localparam int NM = 4;
  localparam int ND = 16;
  localparam int NP = NM + ND;
  localparam logic [12:0] MMASK = 13'h1FFF;
  localparam logic [12:0] DMASK = 13'h07FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NM-1:0][12:0] mux_attr;
  logic [ND-1:0][12:0] ded_attr;

  always #2 clk = ~clk;

  padattr_regfile u_padattr_regfile (
    .clk_i(clk), .rst_i(rst), .cfg_addr_i(addr), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .mux_attr_o(mux_attr), .ded_attr_o(ded_attr)
  );

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t       sb[$];
  logic [12:0] model [NP];
  bit          mlock;
  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] mux_a(int i); return 8'(4 + 4*i); endfunction
  function automatic logic [7:0] ded_a(int j); return 8'(4 + 4*(NM + j)); endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int w;
    if (a[1:0] != 2'b00) return '0;
    w = int'(a[7:2]);
    if (w == 0) return {31'd0, ~mlock};
    if (w <= NP) return {19'd0, model[w-1]};
    return '0;
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    w = int'(a[7:2]);
    if (w == 0) begin
      if (!d[0]) mlock = 1'b1;
    end else if (w <= NP && !mlock) begin
      model[w-1] = d[12:0] & ((w - 1 < NM) ? MMASK : DMASK);
    end
  endtask

  function automatic void chk(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  task automatic op(logic [7:0] a, logic w, logic [31:0] d, string req);
    @(negedge clk);
    addr = a; we = w; wdata = d;
    sb.push_back('{model_read(a), req});
    if (w) model_write(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; addr = '0;
    repeat (2) @(negedge clk);
    chk(rdata, 32'h0, "R1 rdata in reset");
    chk({19'd0, mux_attr[0] | mux_attr[NM-1]}, 32'h0, "R1 mux outputs in reset");
    chk({19'd0, ded_attr[0] | ded_attr[ND-1]}, 32'h0, "R1 ded outputs in reset");
    for (int i = 0; i < NP; i++) model[i] = '0;
    mlock = 1'b0;
    rst = 1'b0;
  endtask

  // monitor: compare read data and all pad outputs after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(rdata, it.exp, it.req);
      for (int i = 0; i < NM; i++)
        chk({19'd0, mux_attr[i]}, {19'd0, model[i]}, "R2 mux output");
      for (int j = 0; j < ND; j++)
        chk({19'd0, ded_attr[j]}, {19'd0, model[NM+j]}, "R2 ded output");
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    op(8'h00, 0, 0, "R1 enable reads 1");
    op(mux_a(0), 0, 0, "R1 pad zero after reset");
    // R2 basic write/read
    op(mux_a(0), 1, 32'h1ABC, "R2 write mux0");
    op(mux_a(0), 0, 0, "R2 read mux0");
    op(ded_a(15), 1, 32'h0155, "R2 write last ded");
    op(ded_a(15), 0, 0, "R2 read last ded");
    // R3 same-cycle read and write of one word
    op(mux_a(1), 1, 32'h0055, "R3 read returns pre-write value");
    op(mux_a(1), 0, 0, "R3 new value visible next");
    // R6 masked drive bits on dedicated pads
    op(ded_a(5), 1, 32'h1FFF, "R6 write all ones ded5");
    op(ded_a(5), 0, 0, "R6 readback 0x07FF");
    // R5 fixed bits writable on a pad whose mask parameter omits them
    op(ded_a(3), 1, 32'h0003, "R5 write inversion and vod");
    op(ded_a(3), 0, 0, "R5 readback 0x3");
    // R10 upper write data discarded
    op(mux_a(3), 1, 32'hFFFF_FFFF, "R10 write all ones");
    op(mux_a(3), 0, 0, "R10 readback 0x1FFF");
    // R4 unmapped addresses
    op(8'h06, 1, 32'h0FFF, "R4 misaligned write");
    op(8'h06, 0, 0, "R4 misaligned reads zero");
    op(8'(4*(NP+1)), 1, 32'h0FFF, "R4 beyond-range write");
    op(8'(4*(NP+1)), 0, 0, "R4 beyond-range reads zero");
    // fill every pad with a distinct pattern
    for (int i = 0; i < NP; i++) op(8'(4 + 4*i), 1, 32'(13'h0A5 ^ (i * 13'h111)), "R2 fill");
    for (int i = 0; i < NP; i++) op(8'(4 + 4*i), 0, 0, "R2 readback fill");
    // R7 lock, then attempted write right after
    op(8'h00, 1, 32'h0, "R7 lock write");
    op(mux_a(0), 1, 32'h0001, "R7 locked write, read old");
    op(mux_a(0), 0, 0, "R7 value unchanged");
    op(ded_a(2), 1, 32'h0000, "R7 locked write ded2");
    op(ded_a(2), 0, 0, "R7 ded2 unchanged");
    // R8 unlock attempt
    op(8'h00, 1, 32'h1, "R8 write 1 while locked");
    op(8'h00, 0, 0, "R8 enable reads 0");
    op(mux_a(2), 1, 32'h0007, "R8 still locked write");
    op(mux_a(2), 0, 0, "R8 value unchanged");
    op(8'h00, 0, 0, "R8 idle");
    @(posedge clk); #2;
    // R9 reset clears lock
    do_reset();
    op(8'h00, 0, 0, "R9 enable reads 1 after reset");
    op(mux_a(2), 1, 32'h0007, "R9 write after reset");
    op(mux_a(2), 0, 0, "R9 readback 0x7");
    op(8'h00, 0, 0, "R9 idle");
    @(posedge clk); #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule